// File: doc/BRIEF.md
# Prioritized interrupt acknowledge unit

This unit lives inside a bus master and decides when an external interrupt request is serviced. Devices present a three-bit priority level on active-low pins. The unit filters that code, compares it with a three-bit mask, and runs an interrupt-acknowledge bus cycle once a request wins. During that cycle it marks the bus transfer as an acknowledge and puts the serviced level on the low address lines. It then captures the eight-bit vector number that the device returns.

The core sees the result as a level and a vector, qualified by a one-cycle strobe. If the cycle ends in a bus error, the core sees a separate one-cycle spurious strobe instead. The mask sits in this unit. The core can rewrite it through a write port, and the unit raises it by itself whenever it starts servicing a request.

Top module: `irq_ack_unit`

## Requirements
- R1: The request level is the bitwise inverse of the three active-low pins `irq_pins_n`. Bit 0 is the least significant bit. Level 0 means no request.
- R2: A level is acted on only after two consecutive clock samples show the same value. A code that is present for a single cycle never starts a cycle.
- R3: Levels 1 to 6 start an acknowledge cycle only when they are strictly greater than the current mask.
- R4: Level 7 starts an acknowledge cycle whatever the mask value is.
- R5: Level 7 is taken only on entry from a lower level. A level 7 that is held after being serviced does not start another cycle, even if the mask is lowered. It is taken again only after the filtered level has first gone below 7.
- R6: While an acknowledge cycle runs, the following outputs are driven:
  - `cyc_strobe` is 1.
  - `func_code` is 3'b111.
  - `addr_out[3:1]` holds the level being serviced.
  - Every higher address bit is 1.
  - Outside a cycle all of these outputs are 0.
- R7: When `xfer_ack` is high in a cycle, the following happens on that clock edge:
  - The cycle ends.
  - `data_lo[7:0]` is captured.
  - `taken_valid` pulses for exactly one cycle, with the level on `taken_level` and the vector on `taken_vector`.
- R8: When `bus_err` is high in a cycle, the cycle ends and `taken_valid` stays 0. Instead, `taken_spur` pulses for one cycle with the level on `taken_level`. If `bus_err` and `xfer_ack` are high together, the bus error wins.
- R9: On the edge where a cycle starts, the mask becomes the serviced level. On any other edge, `mask_we` loads `mask_wdata` into the mask, and the mask is readable on `mask_out`.
- R10: After reset the following holds:
  - The mask is 7.
  - No cycle is active.
  - `taken_valid` and `taken_spur` are 0.

Only one acknowledge cycle can be in progress at a time, and a new one can start on the edge after the previous one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins_n | input | 3 | Encoded request level, active low |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 3 | New mask value |
| mask_out | output | 3 | Current mask |
| cyc_strobe | output | 1 | Acknowledge cycle in progress, address valid |
| func_code | output | 3 | Cycle type, all ones during an acknowledge |
| addr_out | output | 23 | Address bits 23:1 |
| data_lo | input | 8 | Low data byte from the device |
| xfer_ack | input | 1 | Transfer acknowledge |
| bus_err | input | 1 | Bus error |
| taken_valid | output | 1 | One-cycle strobe: vector captured |
| taken_spur | output | 1 | One-cycle strobe: acknowledge ended in bus error |
| taken_level | output | 3 | Level that was serviced |
| taken_vector | output | 8 | Captured vector number |

## Verification
The hardest case to reach is the refusal to take a level 7 that is still held. It only appears after a level-7 request has been serviced and the software has lowered the mask again, while the pins have never left level 7. The bench produces this by keeping the pins at level 7 through a full acknowledge. It then rewrites the mask to 0 and watches for many cycles that no new cycle starts. Next it drops the request to 0 and raises it to 7 again, which must start a new cycle. The one-cycle glitch case is produced in a similar way: a single-cycle level-5 pulse is applied under mask 0 and must never reach the bus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  localparam int FC_W  = 3;
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  function automatic logic [LVL_W-1:0] pins_to_level(input logic [LVL_W-1:0] pins_n);
    return ~pins_n;
  endfunction

  // maskable levels win only above the mask; the top level is handled by edge
  function automatic logic beats_mask(input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] mask);
    return (lvl != LVL_TOP) && (lvl > mask);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_raw,
  output logic [W-1:0] lvl_flt
);
  logic [W-1:0] smp_a, smp_b;
  logic         agree;

  assign agree = (smp_a == smp_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_a   <= '0;
      smp_b   <= '0;
      lvl_flt <= '0;
    end else begin
      smp_a <= lvl_raw;
      smp_b <= smp_a;
      if (agree) lvl_flt <= smp_b;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_flt,
  input  logic [LVL_W-1:0] mask,
  input  logic             bus_idle,
  output logic             take,
  output logic [LVL_W-1:0] take_lvl
);
  logic top_armed;
  logic top_req;

  assign top_req  = (lvl_flt == LVL_TOP) && top_armed;
  assign take     = bus_idle && (top_req || beats_mask(lvl_flt, mask));
  assign take_lvl = lvl_flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    top_armed <= 1'b1;
    else if (lvl_flt != LVL_TOP)   top_armed <= 1'b1;
    else if (take)                 top_armed <= 1'b0;
  end

  AST_TOP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && lvl_flt == LVL_TOP) |=> !(take && lvl_flt == LVL_TOP)); // R5
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_pkg::*;
#(
  parameter int ADDR_MSB = 23,
  parameter int VEC_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [LVL_W-1:0]  take_lvl,
  input  logic              xfer_ack,
  input  logic              bus_err,
  input  logic [VEC_W-1:0]  data_lo,
  output logic              bus_idle,
  output logic              cyc_strobe,
  output logic [FC_W-1:0]   func_code,
  output logic [ADDR_MSB:1] addr_out,
  output logic              taken_valid,
  output logic              taken_spur,
  output logic [LVL_W-1:0]  taken_level,
  output logic [VEC_W-1:0]  taken_vector
);
  localparam int HI_BITS = ADDR_MSB - LVL_W;

  typedef enum logic {ST_IDLE, ST_ACK} st_t;
  st_t              st;
  logic [LVL_W-1:0] cur_lvl;
  logic             cyc_end;

  assign bus_idle   = (st == ST_IDLE);
  assign cyc_strobe = (st == ST_ACK);
  assign cyc_end    = cyc_strobe && (xfer_ack || bus_err);
  assign func_code  = cyc_strobe ? '1 : '0;
  assign addr_out   = cyc_strobe ? {{HI_BITS{1'b1}}, cur_lvl} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      cur_lvl      <= '0;
      taken_valid  <= 1'b0;
      taken_spur   <= 1'b0;
      taken_level  <= '0;
      taken_vector <= '0;
    end else begin
      taken_valid <= 1'b0;
      taken_spur  <= 1'b0;
      if (bus_idle && take) begin
        st      <= ST_ACK;
        cur_lvl <= take_lvl;
      end else if (cyc_end) begin
        st          <= ST_IDLE;
        taken_level <= cur_lvl;
        if (bus_err) begin
          taken_spur <= 1'b1;
        end else begin
          taken_valid  <= 1'b1;
          taken_vector <= data_lo;
        end
      end
    end
  end

  AST_CYCLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && (xfer_ack || bus_err)) |=> !cyc_strobe); // R7
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_valid || taken_spur) |=> !(taken_valid || taken_spur)); // R7
  AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && bus_err) |=> (taken_spur && !taken_valid)); // R8
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_pkg::*;
#(
  parameter int ADDR_MSB = 23,
  parameter int VEC_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        irq_pins_n,
  input  logic              mask_we,
  input  logic [2:0]        mask_wdata,
  output logic [2:0]        mask_out,
  output logic              cyc_strobe,
  output logic [2:0]        func_code,
  output logic [ADDR_MSB:1] addr_out,
  input  logic [VEC_W-1:0]  data_lo,
  input  logic              xfer_ack,
  input  logic              bus_err,
  output logic              taken_valid,
  output logic              taken_spur,
  output logic [2:0]        taken_level,
  output logic [VEC_W-1:0]  taken_vector
);
  logic [LVL_W-1:0] lvl_raw, lvl_flt, take_lvl, mask_q;
  logic             take, bus_idle;

  assign lvl_raw  = pins_to_level(irq_pins_n);
  assign mask_out = mask_q;

  irq_sync #(.W(LVL_W)) i_sync (
    .clk(clk), .rst_n(rst_n), .lvl_raw(lvl_raw), .lvl_flt(lvl_flt));

  irq_arbiter i_arb (
    .clk(clk), .rst_n(rst_n), .lvl_flt(lvl_flt), .mask(mask_q),
    .bus_idle(bus_idle), .take(take), .take_lvl(take_lvl));

  irq_ack_fsm #(.ADDR_MSB(ADDR_MSB), .VEC_W(VEC_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(take_lvl),
    .xfer_ack(xfer_ack), .bus_err(bus_err), .data_lo(data_lo),
    .bus_idle(bus_idle), .cyc_strobe(cyc_strobe), .func_code(func_code),
    .addr_out(addr_out), .taken_valid(taken_valid), .taken_spur(taken_spur),
    .taken_level(taken_level), .taken_vector(taken_vector));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= LVL_TOP;
    else if (take)    mask_q <= take_lvl;
    else if (mask_we) mask_q <= mask_wdata;
  end

  AST_MASK_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_strobe) |-> (mask_out == addr_out[3:1])); // R9
  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cyc_strobe) && addr_out[3:1] != LVL_TOP) |-> ($past(mask_out) < addr_out[3:1])); // R3
  AST_NO_ZERO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe |-> (addr_out[3:1] != 3'd0 && func_code == 3'b111)); // R6
  AST_EXCL_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken_valid && taken_spur)); // R8
endmodule

// File: tb/test_irq_ack_unit.sv
module test_irq_ack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  irq_pins_n = 3'b111;
  logic        mask_we = 1'b0;
  logic [2:0]  mask_wdata = 3'd0;
  logic [2:0]  mask_out;
  logic        cyc_strobe;
  logic [2:0]  func_code;
  logic [23:1] addr_out;
  logic [7:0]  data_lo = 8'h00;
  logic        xfer_ack = 1'b0;
  logic        bus_err = 1'b0;
  logic        taken_valid, taken_spur;
  logic [2:0]  taken_level;
  logic [7:0]  taken_vector;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  irq_ack_unit i_irq_ack_unit (
    .clk(clk), .rst_n(rst_n), .irq_pins_n(irq_pins_n), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .mask_out(mask_out), .cyc_strobe(cyc_strobe),
    .func_code(func_code), .addr_out(addr_out), .data_lo(data_lo),
    .xfer_ack(xfer_ack), .bus_err(bus_err), .taken_valid(taken_valid),
    .taken_spur(taken_spur), .taken_level(taken_level), .taken_vector(taken_vector));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mask(input logic [2:0] m);
    @(negedge clk); mask_we = 1'b1; mask_wdata = m;
    @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic wait_cycle(input int max, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < max && !seen; i++) begin
      @(negedge clk);
      if (cyc_strobe) seen = 1'b1;
    end
  endtask

  // at a negedge with cyc_strobe high: acknowledge with vector and check result
  task automatic finish_ok(input logic [2:0] lvl, input logic [7:0] vec);
    check("R6 func_code", func_code, 3'b111);
    check("R6 addr level", addr_out[3:1], lvl);
    check("R6 addr upper", addr_out[23:4], 20'hFFFFF);
    check("R9 mask raised", mask_out, lvl);
    data_lo = vec; xfer_ack = 1'b1;
    @(negedge clk); xfer_ack = 1'b0;
    check("R7 valid", taken_valid, 1'b1);
    check("R7 vector", taken_vector, vec);
    check("R7 level", taken_level, lvl);
    check("R7 cycle end", cyc_strobe, 1'b0);
    @(negedge clk);
    check("R7 one cycle", taken_valid, 1'b0);
  endtask

  task automatic release_req();
    irq_pins_n = 3'b111;
    repeat (4) @(negedge clk);
  endtask

  // {mask, level, expect_take, vector}
  localparam logic [14:0] TBL [0:8] = '{
    {3'd0, 3'd3, 1'b1, 8'h41},
    {3'd3, 3'd3, 1'b0, 8'h00},
    {3'd3, 3'd4, 1'b1, 8'h5A},
    {3'd5, 3'd2, 1'b0, 8'h00},
    {3'd6, 3'd7, 1'b1, 8'h1F},
    {3'd7, 3'd7, 1'b1, 8'hC3},
    {3'd7, 3'd6, 1'b0, 8'h00},
    {3'd0, 3'd1, 1'b1, 8'h99},
    {3'd0, 3'd0, 1'b0, 8'h00}
  };

  initial begin
    logic seen;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 mask", mask_out, 3'd7);
    check("R10 strobe", cyc_strobe, 1'b0);
    check("R10 valid", taken_valid, 1'b0);
    check("R6 idle func_code", func_code, 3'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R1 R3 R4 R6 R7 R9
    for (int r = 0; r < 9; r++) begin
      logic [2:0] m, l;
      logic       e;
      logic [7:0] v;
      {m, l, e, v} = TBL[r];
      set_mask(m);
      check("R9 mask write", mask_out, m);
      irq_pins_n = ~l;
      wait_cycle(12, seen);
      check(l == 3'd7 ? "R4 take" : "R3 take", seen, e);
      if (seen) finish_ok(l, v);
      release_req();
    end

    // R2 single-cycle glitch
    set_mask(3'd0);
    @(negedge clk); irq_pins_n = ~3'd5;
    @(negedge clk); irq_pins_n = 3'b111;
    wait_cycle(12, seen);
    check("R2 glitch ignored", seen, 1'b0);
    check("R2 mask unchanged", mask_out, 3'd0);

    // R5 held level 7 not retaken
    irq_pins_n = ~3'd7;
    wait_cycle(12, seen);
    check("R5 first take", seen, 1'b1);
    if (seen) finish_ok(3'd7, 8'h77);
    set_mask(3'd0);
    wait_cycle(20, seen);
    check("R5 held not retaken", seen, 1'b0);
    release_req();
    irq_pins_n = ~3'd7;
    wait_cycle(12, seen);
    check("R5 retaken after drop", seen, 1'b1);
    if (seen) finish_ok(3'd7, 8'h78);
    release_req();

    // R8 bus error wins over transfer acknowledge
    set_mask(3'd0);
    irq_pins_n = ~3'd4;
    wait_cycle(12, seen);
    check("R8 take", seen, 1'b1);
    data_lo = 8'hEE; bus_err = 1'b1; xfer_ack = 1'b1;
    @(negedge clk); bus_err = 1'b0; xfer_ack = 1'b0;
    check("R8 spur", taken_spur, 1'b1);
    check("R8 no valid", taken_valid, 1'b0);
    check("R8 level", taken_level, 3'd4);
    check("R8 cycle end", cyc_strobe, 1'b0);
    @(negedge clk);
    check("R8 spur one cycle", taken_spur, 1'b0);
    release_req();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule